// File: doc/BRIEF.md
# UART Oversampling Receiver with Error Status

This block turns an asynchronous serial line into parallel characters. It is timed by `os_tick`, a one-cycle enable that pulses sixteen times per bit period. While idle the line rests high. A low level starts a bit-period count. The receiver confirms the start bit half a bit later, then samples each following bit at its middle. It checks an optional parity bit and the stop bit, and it recognises a line held low for a whole frame as a break.

Each finished character goes to a downstream receive queue as a 12-bit word with a one-cycle push strobe. The word carries the data and four error flags. When the queue reports full, the character is dropped. The loss is then flagged on the next character that is stored. The word length (5 to 8 bits) and the parity mode come from static configuration inputs.

Top module: `uart_rx_sampler`

## Requirements
- R1: After reset `push` is low, and no word is pushed while the line stays high.
- R2: A low level that is no longer low at the 8th oversample tick after it was first seen is a false start. It is discarded without a push, and the receiver then accepts the next valid frame normally.
- R3: After a valid start, each data bit is sampled every 16 ticks and taken least significant bit first. For 8-bit characters the data appears in `push_word[7:0]`.
- R4: `word_len` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. The data bits of `push_word` above the selected length read zero.
- R5: With `par_en` high, one parity bit follows the data. `par_odd` low selects even parity and high selects odd parity. A mismatch sets `push_word[9]`.
- R6: A low stop sample sets the framing flag `push_word[8]`. The receiver then waits for the line to return high before it looks for a new start.
- R7: When the data, parity and stop samples are all low, the word is pushed with the break flag `push_word[10]` and the framing flag set and with data zero. No further word follows until the line has gone high again.
- R8: A character that completes while `full` is high is not pushed. The next pushed word carries the overrun flag `push_word[11]`, which is then cleared.
- R9: `push` is high for exactly one clock per stored character, in the cycle after the `os_tick` that sampled the stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| word_len | input | 2 | Character length code (0 = 5 bits … 3 = 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when high, even when low |
| full | input | 1 | Receive queue cannot accept a word |
| push | output | 1 | One-cycle write strobe to the queue |
| push_word | output | 12 | {overrun, break, parity err, framing err, data[7:0]} |

## Verification
A table of frames exercises every word length and both parity senses, using correct and corrupted parity bits and good and low stop bits. This separates the data path from each error flag. A low glitch shorter than half a bit period, followed by a real frame, shows that the mid-bit start check rejects the glitch and does not disturb the next frame. A long low level shows that a break is pushed once and that a new frame is accepted once the line returns high. A frame received while `full` is high, followed by a normal frame, shows both the drop and the overrun flag being carried to the next stored word.

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rx_line,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        full,
  output logic        push,
  output logic [11:0] push_word
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [1:0] sync;
  logic [CW-1:0] cnt;
  logic [2:0] nbit;
  logic [7:0] sh;
  logic       parbit, ovr_pend;

  wire       rx_s     = sync[1];
  wire       last_tck = (cnt == CW'(OSR - 1));
  wire [7:0] data_c   = sh >> (2'd3 - word_len);
  wire       pe_c     = par_en & (^data_c ^ parbit ^ par_odd);
  wire       brk_c    = (data_c == 8'd0) & ~(par_en & parbit) & ~rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sync      <= 2'b11;
      cnt       <= '0;
      nbit      <= '0;
      sh        <= '0;
      parbit    <= 1'b0;
      ovr_pend  <= 1'b0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      push <= 1'b0;
      sync <= {sync[0], rx_line};
      if (os_tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
          S_START: if (cnt == CW'(MID - 1)) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
          S_DATA: if (last_tck) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[7:1]};
            nbit <= nbit + 1'b1;
            if (nbit == {1'b0, word_len} + 3'd4) st <= par_en ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
          S_PAR: if (last_tck) begin
            cnt    <= '0;
            parbit <= rx_s;
            st     <= S_STOP;
          end else cnt <= cnt + 1'b1;
          S_STOP: if (last_tck) begin
            cnt <= '0;
            st  <= rx_s ? S_IDLE : S_HOLD;
            if (full) ovr_pend <= 1'b1;
            else begin
              push      <= 1'b1;
              push_word <= {ovr_pend, brk_c, pe_c, ~rx_s, data_c};
              ovr_pend  <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
          S_HOLD: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_rx_sampler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        os_tick,
  input logic [1:0]  word_len,
  input logic        full,
  input logic        push,
  input logic [11:0] push_word
);
  // R9
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n) push |=> !push);
  // R9
  push_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> $past(os_tick));
  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push) |-> !$past(full));
  // R4
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && word_len == 2'd0) |-> (push_word[7:5] == 3'd0));
  // R7
  break_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_word[10]) |-> (push_word[8] && push_word[7:0] == 8'd0));
endmodule

bind uart_rx_sampler uart_rx_sampler_chk u_chk (.*);

// File: tb/sim_uart_rx_sampler.sv
module sim_uart_rx_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int BT = 64;
  localparam int NV = 7;
  // {word_len, par_en, par_odd, bad_par, bad_stop, 2'b0, data} , expected word
  localparam logic [27:0] VEC [NV] = '{
    28'hC0A50A5, 28'hE03C03C, 28'hF03C03C, 28'hA855255,
    28'h00FF01F, 28'h442A12A, 28'hF000000
  };

  logic clk = 0, rst_n = 0, os_tick = 0, rx_line = 1, par_en = 0, par_odd = 0, full = 0;
  logic [1:0] word_len = 2'd3;
  logic push;
  logic [11:0] push_word;
  logic [1:0] div = 0;
  logic [11:0] got [64];
  int ncap = 0, run = 0, maxrun = 0, nchk = 0, nfail = 0;
  bit done = 0;

  uart_rx_sampler u0 (.clk, .rst_n, .os_tick, .rx_line, .word_len, .par_en,
                      .par_odd, .full, .push, .push_word);

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) begin
    div <= div + 1'b1;
    os_tick <= (div == 2'd3);
  end

  always @(negedge clk) begin
    if (push) begin
      got[ncap % 64] = push_word;
      ncap++;
      run++;
      if (run > maxrun) maxrun = run;
    end else run = 0;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] len, input logic pen, input logic podd,
                      input logic bpar, input logic bstop, input logic [7:0] d);
    logic [7:0] dm;
    dm = d & (8'hFF >> (3 - len));
    word_len = len; par_en = pen; par_odd = podd;
    rx_line = 0; repeat (BT) @(negedge clk);
    for (int i = 0; i < int'(len) + 5; i++) begin
      rx_line = d[i]; repeat (BT) @(negedge clk);
    end
    if (pen) begin
      rx_line = ^dm ^ podd ^ bpar; repeat (BT) @(negedge clk);
    end
    rx_line = ~bstop; repeat (BT) @(negedge clk);
    idle(2 * BT);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1;
    idle(3 * BT);
    // R1
    check("R1 reset/idle push count", ncap, 0);

    for (int v = 0; v < NV; v++) begin
      base = ncap;
      send(VEC[v][27:26], VEC[v][25], VEC[v][24], VEC[v][23], VEC[v][22], VEC[v][19:12]);
      // R3 R4 R5 R6
      check($sformatf("R3/R4/R5/R6 vector %0d word", v), got[base % 64], VEC[v][11:0]);
    end

    // R2: short glitch
    base = ncap;
    rx_line = 0; repeat (20) @(negedge clk);
    idle(2 * BT);
    check("R2 false start no push", ncap, base);
    send(2'd3, 0, 0, 0, 0, 8'h5A);
    check("R2 frame after false start", got[base % 64], 12'h05A);

    // R7: break
    base = ncap;
    word_len = 2'd3; par_en = 0;
    rx_line = 0; repeat (12 * BT) @(negedge clk);
    check("R7 break single push", ncap, base + 1);
    check("R7 break word", got[base % 64], 12'h500);
    idle(2 * BT);
    check("R7 no push on release", ncap, base + 1);
    send(2'd3, 0, 0, 0, 0, 8'h81);
    check("R7 frame after break", got[(base + 1) % 64], 12'h081);

    // R8: overrun
    base = ncap;
    full = 1;
    send(2'd3, 0, 0, 0, 0, 8'h33);
    full = 0;
    check("R8 dropped while full", ncap, base);
    send(2'd3, 0, 0, 0, 0, 8'h12);
    check("R8 overrun on next word", got[base % 64], 12'h812);
    base = ncap;
    send(2'd3, 0, 0, 0, 0, 8'h12);
    check("R8 overrun cleared", got[base % 64], 12'h012);

    // R9
    check("R9 push width", maxrun, 1);
    finish_up();
  end
endmodule